// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This controller sits beside a small signal-processing sequencer. It collects a reset request and six interrupt sources, and picks the one to serve. It then tells the sequencer which vector to jump to. Each source is edge- or level-sensitive, as a build parameter sets. Edge sources keep a pending bit. Software can set or drop that bit through a force/clear write. An enable mask gates every source, and a fixed priority resolves conflicts: the lower the vector address, the more urgent the source.

When a source is taken, the controller does three things. It pulses `accept` with the vector address. It saves the caller's arithmetic status word, mode status word and current enable mask as one entry on a bounded context stack. It then narrows the enable mask so that only more urgent sources can nest. A return strobe pops the newest entry and hands the three words back. The popped mask becomes active again, so sources that were held off can then be served. Misuse of the stack leaves a sticky flag. A push refused because the stack is full sets `overflow`, and a pop from an empty stack sets `underflow`.

Top module: `prio_vec_intc`

## Requirements
- R1: Source index i (0..5, bit i of `irqIn`) is served at vector address 4*(i+1): bit 0 at 0x0004 up to bit 5 at 0x0018. A reset request is served at 0x0000.
- R2: When several unmasked sources are pending, the lowest index wins.
- R3: An edge source becomes pending on a rising edge of its input, and stays pending until it is served or cleared. A level source is pending only while its sampled input is high. With the default parameter, bits 3 and 4 are level-sensitive.
- R4: A write with `fcWe` high applies two fields to edge sources: bit i of `forceBits` makes source i pending, and bit i of `clearBits` drops it. Clear wins over force. Level sources ignore both fields.
- R5: A source is served only while its bit in `curMask` is 1. Serving source i replaces the mask with its bits below i. A mask write in the same cycle takes precedence over this narrowing.
- R6: Each service pushes {`arithStat`, `modeStat`, `curMask`}, sampled in the serving cycle, as one entry. A successful pop pulses `restValid` for one cycle, with the entry presented in last-in first-out order.
- R7: The stack holds DEPTH = 7 entries. While it is full, no source is served. Any such refused service sets `overflow`, which stays set until reset.
- R8: A pop on an empty stack sets `underflow`, which stays set until reset. It also leaves `restValid` low and `curMask` unchanged.
- R9: A return strobe blocks service in its own cycle. The popped mask is visible on `curMask` right after that edge, so a held-off request is served on the next edge.
- R10: `resetReq` sampled high pulses `accept` with vector 0. It also empties the stack, clears all latched pending bits, zeroes the mask and clears both flags.
- R11: `accept` is a one-cycle pulse. It appears two clock edges after a request is raised: one edge to sample the request, one to serve it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| resetReq | input | 1 | Non-maskable reset request (vector 0) |
| irqIn | input | NUM_SRC | Interrupt request lines, bit 0 most urgent |
| maskWe | input | 1 | Load `maskIn` into the enable mask |
| maskIn | input | NUM_SRC | New enable mask, 1 = enabled |
| fcWe | input | 1 | Apply force/clear fields |
| forceBits | input | NUM_SRC | Per-source force field |
| clearBits | input | NUM_SRC | Per-source clear field |
| arithStat | input | STAT_W | Arithmetic status word to save |
| modeStat | input | STAT_W | Mode status word to save |
| rtiStrobe | input | 1 | Return-from-interrupt, pops one entry |
| vecAddr | output | VEC_W | Vector of the last served request |
| accept | output | 1 | One-cycle service pulse |
| curMask | output | NUM_SRC | Active enable mask |
| restValid | output | 1 | Popped entry valid pulse |
| restArith | output | STAT_W | Restored arithmetic status |
| restMode | output | STAT_W | Restored mode status |
| restMask | output | NUM_SRC | Restored mask word |
| overflow | output | 1 | Sticky: service refused on full stack |
| underflow | output | 1 | Sticky: pop on empty stack |

## Verification
Some properties are checked on every cycle: vector alignment and range, flag stickiness, the reset-request vector, no service in a return cycle, mask narrowing after a service, and that each restore follows a return strobe. Other behaviour needs the bench's scenarios. These cover which source wins for each pair of sources, and the exact content and order of restored entries. They also cover force/clear on edge versus level sources, refusal at a depth of seven, and the hand-off to a held-off request after the mask is restored.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
  typedef struct packed {
    logic flush;
    logic push;
    logic pop;
    logic overflowHit;
  } stackCmd_t;
endpackage

// File: rtl/pvi_ctrl.sv
module pvi_ctrl
  import pvi_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int VEC_W = 16,
  parameter int VEC_STEP = 4,
  parameter logic [NUM_SRC-1:0] LEVEL_SRC = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetReq,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               maskWe,
  input  logic [NUM_SRC-1:0] maskIn,
  input  logic               fcWe,
  input  logic [NUM_SRC-1:0] forceBits,
  input  logic [NUM_SRC-1:0] clearBits,
  input  logic               rtiStrobe,
  input  logic               stackFull,
  input  logic               stackEmpty,
  input  logic [NUM_SRC-1:0] topMask,
  output stackCmd_t          cmd,
  output logic               accept,
  output logic [VEC_W-1:0]   vecAddr,
  output logic [NUM_SRC-1:0] curMask
);
  localparam int IDX_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] prevIrq, pendEdge, pendEff, cand, rise;
  logic [NUM_SRC-1:0] forceEff, clearEff, servedBit, aboveMask;
  logic [IDX_W-1:0]   winIdx;
  logic               anyCand, canTake;

  // sampled level for level sources, latched bit for edge sources
  always_comb begin
    rise     = irqIn & ~prevIrq;
    pendEff  = (LEVEL_SRC & prevIrq) | (~LEVEL_SRC & pendEdge);
    cand     = pendEff & curMask;
    anyCand  = |cand;
    forceEff = fcWe ? (forceBits & ~LEVEL_SRC) : '0;
    clearEff = fcWe ? (clearBits & ~LEVEL_SRC) : '0;
  end

  // fixed priority: lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) winIdx = IDX_W'(i);
    end
  end

  always_comb begin
    canTake         = !resetReq && !rtiStrobe && anyCand;
    cmd.flush       = resetReq;
    cmd.pop         = rtiStrobe && !resetReq;
    cmd.push        = canTake && !stackFull;
    cmd.overflowHit = canTake && stackFull;
    servedBit       = cmd.push ? (NUM_SRC'(1) << winIdx) : '0;
    aboveMask       = (NUM_SRC'(1) << winIdx) - NUM_SRC'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIrq  <= '0;
      pendEdge <= '0;
      curMask  <= '0;
      accept   <= 1'b0;
      vecAddr  <= '0;
    end else begin
      prevIrq <= irqIn;
      accept  <= resetReq || cmd.push;
      if (resetReq) begin
        vecAddr  <= '0;
        pendEdge <= '0;
        curMask  <= '0;
      end else begin
        if (cmd.push)
          vecAddr <= VEC_W'((32'(winIdx) + 32'd1) * 32'(VEC_STEP));
        pendEdge <= (((pendEdge & ~servedBit) | rise | forceEff) & ~clearEff) & ~LEVEL_SRC;
        if (cmd.pop && !stackEmpty) curMask <= topMask;
        else if (maskWe)            curMask <= maskIn;
        else if (cmd.push)          curMask <= curMask & aboveMask;
      end
    end
  end
endmodule

// File: rtl/pvi_ctx_stack.sv
module pvi_ctx_stack
  import pvi_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int STAT_W = 16,
  parameter int DEPTH = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  stackCmd_t          cmd,
  input  logic [STAT_W-1:0]  pushArith,
  input  logic [STAT_W-1:0]  pushMode,
  input  logic [NUM_SRC-1:0] pushMask,
  output logic               full,
  output logic               empty,
  output logic [NUM_SRC-1:0] topMask,
  output logic               restValid,
  output logic [STAT_W-1:0]  restArith,
  output logic [STAT_W-1:0]  restMode,
  output logic [NUM_SRC-1:0] restMask,
  output logic               overflow,
  output logic               underflow
);
  localparam int ENTRY_W = 2 * STAT_W + NUM_SRC;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]   count;
  logic [PTR_W-1:0]   topIdx, wrIdx;
  logic [ENTRY_W-1:0] topEntry;

  always_comb begin
    full     = (count == CNT_W'(DEPTH));
    empty    = (count == '0);
    topIdx   = empty ? '0 : PTR_W'(count - CNT_W'(1));
    wrIdx    = PTR_W'(count);
    topEntry = mem[topIdx];
    topMask  = topEntry[NUM_SRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (cmd.push && !cmd.flush && !full)
      mem[wrIdx] <= {pushArith, pushMode, pushMask};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      restValid <= 1'b0;
      restArith <= '0;
      restMode  <= '0;
      restMask  <= '0;
    end else begin
      restValid <= 1'b0;
      if (cmd.flush) begin
        count     <= '0;
        overflow  <= 1'b0;
        underflow <= 1'b0;
      end else begin
        if (cmd.push && !full) count <= count + CNT_W'(1);
        if (cmd.overflowHit) overflow <= 1'b1;
        if (cmd.pop) begin
          if (empty) underflow <= 1'b1;
          else begin
            count     <= count - CNT_W'(1);
            restValid <= 1'b1;
            {restArith, restMode, restMask} <= topEntry;
          end
        end
      end
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvi_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int STAT_W = 16,
  parameter int VEC_W = 16,
  parameter int DEPTH = 7,
  parameter logic [NUM_SRC-1:0] LEVEL_SRC = 6'b011000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetReq,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic               maskWe,
  input  logic [NUM_SRC-1:0] maskIn,
  input  logic               fcWe,
  input  logic [NUM_SRC-1:0] forceBits,
  input  logic [NUM_SRC-1:0] clearBits,
  input  logic [STAT_W-1:0]  arithStat,
  input  logic [STAT_W-1:0]  modeStat,
  input  logic               rtiStrobe,
  output logic [VEC_W-1:0]   vecAddr,
  output logic               accept,
  output logic [NUM_SRC-1:0] curMask,
  output logic               restValid,
  output logic [STAT_W-1:0]  restArith,
  output logic [STAT_W-1:0]  restMode,
  output logic [NUM_SRC-1:0] restMask,
  output logic               overflow,
  output logic               underflow
);
  localparam int VEC_STEP = 4;

  stackCmd_t          cmd;
  logic               stackFull, stackEmpty;
  logic [NUM_SRC-1:0] topMask;

  pvi_ctrl #(
    .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP), .LEVEL_SRC(LEVEL_SRC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .irqIn(irqIn),
    .maskWe(maskWe), .maskIn(maskIn), .fcWe(fcWe), .forceBits(forceBits),
    .clearBits(clearBits), .rtiStrobe(rtiStrobe), .stackFull(stackFull),
    .stackEmpty(stackEmpty), .topMask(topMask), .cmd(cmd), .accept(accept),
    .vecAddr(vecAddr), .curMask(curMask)
  );

  pvi_ctx_stack #(
    .NUM_SRC(NUM_SRC), .STAT_W(STAT_W), .DEPTH(DEPTH)
  ) uStack (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pushArith(arithStat),
    .pushMode(modeStat), .pushMask(curMask), .full(stackFull),
    .empty(stackEmpty), .topMask(topMask), .restValid(restValid),
    .restArith(restArith), .restMode(restMode), .restMask(restMask),
    .overflow(overflow), .underflow(underflow)
  );
endmodule

// File: rtl/pvi_checker.sv
module pvi_checker #(
  parameter int NUM_SRC = 6,
  parameter int VEC_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               resetReq,
  input logic               rtiStrobe,
  input logic               maskWe,
  input logic               accept,
  input logic [VEC_W-1:0]   vecAddr,
  input logic [NUM_SRC-1:0] curMask,
  input logic               restValid,
  input logic               overflow,
  input logic               underflow
);
  assert_vec_aligned_R1: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> (vecAddr[1:0] == 2'b00) && (32'(vecAddr) <= 4 * NUM_SRC));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !resetReq |=> overflow);

  assert_udf_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    underflow && !resetReq |=> underflow);

  assert_rti_blocks_R9: assert property (@(posedge clk) disable iff (!rstN)
    rtiStrobe && !resetReq |=> !accept);

  assert_reset_vec_R10: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> accept && (vecAddr == '0));

  assert_mask_narrow_R5: assert property (@(posedge clk) disable iff (!rstN)
    accept && (vecAddr != '0) && !$past(maskWe)
      |-> ((curMask >> ((vecAddr >> 2) - VEC_W'(1))) == '0));

  assert_restore_after_rti_R6: assert property (@(posedge clk) disable iff (!rstN)
    restValid |-> $past(rtiStrobe));
endmodule

bind prio_vec_intc pvi_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) uChk (
  .clk(clk), .rstN(rstN), .resetReq(resetReq), .rtiStrobe(rtiStrobe),
  .maskWe(maskWe), .accept(accept), .vecAddr(vecAddr), .curMask(curMask),
  .restValid(restValid), .overflow(overflow), .underflow(underflow)
);

// File: tb/sim_prio_vec_intc.sv
module sim_prio_vec_intc;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 6;
  localparam int SW = 16;
  localparam int VW = 16;
  localparam int DEPTH = 7;
  localparam logic [NS-1:0] LEVEL = 6'b011000;
  localparam logic [NS-1:0] ALL = '1;

  logic clk = 1'b0, rstN = 1'b0, resetReq = 1'b0;
  logic [NS-1:0] irqIn = '0, maskIn = '0, forceBits = '0, clearBits = '0;
  logic maskWe = 1'b0, fcWe = 1'b0, rtiStrobe = 1'b0;
  logic [SW-1:0] arithStat = '0, modeStat = '0;
  logic [VW-1:0] vecAddr;
  logic accept, restValid, overflow, underflow;
  logic [NS-1:0] curMask, restMask;
  logic [SW-1:0] restArith, restMode;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_vec_intc #(.NUM_SRC(NS), .STAT_W(SW), .VEC_W(VW), .DEPTH(DEPTH), .LEVEL_SRC(LEVEL)) u0 (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .irqIn(irqIn), .maskWe(maskWe),
    .maskIn(maskIn), .fcWe(fcWe), .forceBits(forceBits), .clearBits(clearBits),
    .arithStat(arithStat), .modeStat(modeStat), .rtiStrobe(rtiStrobe),
    .vecAddr(vecAddr), .accept(accept), .curMask(curMask), .restValid(restValid),
    .restArith(restArith), .restMode(restMode), .restMask(restMask),
    .overflow(overflow), .underflow(underflow)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    maskWe = 0; fcWe = 0; rtiStrobe = 0; resetReq = 0;
    forceBits = '0; clearBits = '0;
  endtask

  task automatic setMask(input logic [NS-1:0] m);
    maskWe = 1; maskIn = m; tick(); maskWe = 0;
  endtask

  task automatic pop();
    rtiStrobe = 1; tick(); rtiStrobe = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    tick(); tick();
    rstN = 1;
    // reset state
    chk("R11 accept idle", 32'(accept), 0);
    chk("R5 mask zero", 32'(curMask), 0);
    chk("R7 overflow clear", 32'(overflow), 0);
    chk("R8 underflow clear", 32'(underflow), 0);

    // R1 R3 R5 R6 R11: every source alone
    for (int i = 0; i < NS; i++) begin
      setMask(ALL);
      arithStat = SW'(100 + i); modeStat = SW'(200 + i);
      irqIn[i] = 1'b1; tick();
      chk("R11 no accept after one edge", 32'(accept), 0);
      tick();
      chk("R11 accept pulse", 32'(accept), 1);
      chk("R1 vector", 32'(vecAddr), 32'(4 * (i + 1)));
      chk("R5 narrowed mask", 32'(curMask), 32'((1 << i) - 1));
      irqIn[i] = 1'b0; tick();
      chk("R3 no repeat service", 32'(accept), 0);
      pop();
      chk("R6 restValid", 32'(restValid), 1);
      chk("R6 arith word", 32'(restArith), 32'(100 + i));
      chk("R6 mode word", 32'(restMode), 32'(200 + i));
      chk("R6 mask word", 32'(restMask), 32'(ALL));
      chk("R9 mask restored", 32'(curMask), 32'(ALL));
      tick();
      chk("R3 pending dropped", 32'(accept), 0);
    end

    // R2 R9: every pair raised together
    for (int i = 0; i < NS; i++) begin
      for (int j = i + 1; j < NS; j++) begin
        setMask(ALL);
        irqIn[i] = 1'b1; irqIn[j] = 1'b1; tick(); tick();
        chk("R2 winner", 32'(vecAddr), 32'(4 * (i + 1)));
        chk("R2 accept", 32'(accept), 1);
        irqIn[i] = 1'b0; tick();
        chk("R5 loser held off", 32'(accept), 0);
        pop();
        chk("R9 no accept on return", 32'(accept), 0);
        tick();
        chk("R9 held-off served", 32'(accept), 1);
        chk("R9 held-off vector", 32'(vecAddr), 32'(4 * (j + 1)));
        irqIn[j] = 1'b0;
        pop();
        tick();
        chk("R3 quiet after pair", 32'(accept), 0);
      end
    end

    // R4 force/clear
    setMask('0);
    fcWe = 1; forceBits = 6'b000001; tick(); idle();
    setMask(6'b000001); tick();
    chk("R4 force makes pending", 32'(accept), 1);
    chk("R4 forced vector", 32'(vecAddr), 32'h4);
    pop();
    setMask('0);
    fcWe = 1; forceBits = 6'b000010; tick(); idle();
    fcWe = 1; clearBits = 6'b000010; tick(); idle();
    setMask(ALL); tick();
    chk("R4 clear drops pending", 32'(accept), 0);
    setMask('0);
    fcWe = 1; forceBits = 6'b000100; clearBits = 6'b000100; tick(); idle();
    setMask(ALL); tick();
    chk("R4 clear beats force", 32'(accept), 0);
    setMask('0);
    fcWe = 1; forceBits = 6'b001000; tick(); idle();
    setMask(ALL); tick();
    chk("R4 level ignores force", 32'(accept), 0);
    irqIn[3] = 1'b1; fcWe = 1; clearBits = 6'b001000; tick(); idle();
    tick();
    chk("R4 level ignores clear", 32'(accept), 1);
    chk("R4 level vector", 32'(vecAddr), 32'h10);
    irqIn[3] = 1'b0;
    pop();

    // R7 fill the stack, R6 LIFO, R8 underflow
    for (int k = 0; k < DEPTH; k++) begin
      arithStat = SW'(k);
      maskWe = 1; maskIn = ALL; fcWe = 1; forceBits = 6'b100000; tick(); idle();
      tick();
      chk("R7 push accepted", 32'(accept), 1);
      chk("R1 timer vector", 32'(vecAddr), 32'h18);
    end
    maskWe = 1; maskIn = ALL; fcWe = 1; forceBits = 6'b100000; tick(); idle();
    tick();
    chk("R7 full refuses", 32'(accept), 0);
    chk("R7 overflow set", 32'(overflow), 1);
    fcWe = 1; clearBits = 6'b100000; tick(); idle();
    for (int p = 0; p < DEPTH; p++) begin
      pop();
      chk("R6 pop valid", 32'(restValid), 1);
      chk("R6 LIFO order", 32'(restArith), 32'(DEPTH - 1 - p));
    end
    chk("R7 overflow sticky", 32'(overflow), 1);
    chk("R8 underflow not yet", 32'(underflow), 0);
    pop();
    chk("R8 underflow set", 32'(underflow), 1);
    chk("R8 no restValid", 32'(restValid), 0);
    chk("R8 mask unchanged", 32'(curMask), 32'(ALL));
    tick();
    chk("R8 underflow sticky", 32'(underflow), 1);

    // R10 reset request
    setMask(ALL);
    fcWe = 1; forceBits = 6'b000001; tick(); idle();
    tick();
    chk("R10 pre push", 32'(accept), 1);
    fcWe = 1; forceBits = 6'b000010; tick(); idle();
    resetReq = 1; tick(); resetReq = 0;
    chk("R10 accept", 32'(accept), 1);
    chk("R10 vector zero", 32'(vecAddr), 0);
    chk("R10 mask zero", 32'(curMask), 0);
    chk("R10 flags cleared", 32'({overflow, underflow}), 0);
    setMask(ALL); tick();
    chk("R10 pending cleared", 32'(accept), 0);
    pop();
    chk("R10 stack emptied", 32'(underflow), 1);
    chk("R10 no restore", 32'(restValid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule